// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core

This block is the device side of a synchronous static RAM that moves two data words in each clock period. Commands are taken on the rising clock edge. An active-low strobe starts a transaction, a direction bit picks read or write, and a word address is captured with them. Each transaction carries two words. The low bit of the captured address orders those two words.

The two halves of the clock period are modelled as two beat ports, rise and fall, in a single clock domain. Write data and the active-low lane enables for both beats arrive in the cycle after the write command. Read words leave through the two output beats, marked by a valid flag, a fixed number of clocks after the read command. A static input chooses which clock the read data is referenced to:

- the input clock (output clocks held high), or
- the separate output clock pair, which costs one more register stage.

A free-running complementary echo pair toggles on every cycle.

Top module: `b2sram_core`

## Requirements
- R1: With `load_n` low at a rising edge, `rw` high starts a read and `rw` low starts a write. With `load_n` high, nothing starts: no read beats are returned and the array is not changed.
- R2: A read of address A returns the word at A on `rd_rise` and the word at A XOR 1 on `rd_fall`.
- R3: A write command at address A takes its data in the next cycle. `wd_rise` goes to word A and `wd_fall` goes to word A XOR 1.
- R4: The lane enables are active low, one per 9-bit lane. Lane 0 is bits 8:0 and lane 1 is bits 17:9. `wbe_rise_n` masks the rise beat and `wbe_fall_n` masks the fall beat. A lane whose enable is high keeps its old contents.
- R5: During the data cycle of a write, the address on the `addr` port does not redirect the pending write. The address and `rw` are ignored whenever `load_n` is high.
- R6: With `oref_tied` high, read beats appear with `rd_valid` high after RD_EXTRA+1 further rising edges following the edge that captured the read. With `oref_tied` low, they appear one edge later.
- R7: When no read beat is being returned, `rd_valid` is low and `rd_rise` and `rd_fall` are zero.
- R8: A read captured in the cycle right after a write command to the same word pair returns the newly written lanes, with that write's lane enables applied.
- R9: `echo_p` toggles on every rising edge out of reset, whatever the traffic, and `echo_n` is always its complement.
- R10: During a synchronous reset, `rd_valid` is low, the data beats are zero, `echo_p` is low, `echo_n` is high, and any pending write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; rising edge captures commands and both beats |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low transaction strobe |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Word address; bit 0 orders the burst |
| wd_rise | input | 18 | Write data, first beat |
| wd_fall | input | 18 | Write data, second beat |
| wbe_rise_n | input | 2 | Active-low lane enables, first beat |
| wbe_fall_n | input | 2 | Active-low lane enables, second beat |
| oref_tied | input | 1 | 1: output clocks held high (input clock reference); 0: output clocks used |
| rd_valid | output | 1 | Read beats valid |
| rd_rise | output | 18 | Read data, first beat |
| rd_fall | output | 18 | Read data, second beat |
| echo_p | output | 1 | Free-running echo clock |
| echo_n | output | 1 | Complement of echo_p |

## Verification
A wrong pending-write address or a lost write stays hidden until a later read of that word pair. The bench therefore reads every word after filling the array and keeps reading at random, so a bad entry shows on `rd_rise` or `rd_fall` within a few cycles of the next access to it. A swapped beat order or a wrong lane mask shows as halves or 9-bit lanes of the returned word exchanged or stale, at the first read of an odd address or a partly masked write. A pipeline depth or reference-select error moves `rd_valid` by one cycle and is caught on the very first read in each reference mode. Write-then-read pairs on the same words expose a missing forwarding path on the cycle the data is returned.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic load_n, input logic rw);
    if (load_n) return OP_IDLE;
    return rw ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/b2sram_cmd.sv
// Command capture: read request goes straight to the array, write waits one
// cycle for its data beats.
module b2sram_cmd #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned ROW_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_req,
  output logic [ROW_W-1:0]  rd_row,
  output logic              rd_vld_q,
  output logic              rd_a0_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  import b2sram_pkg::*;

  op_e op;

  always_comb begin
    op     = decode_op(load_n, rw);
    rd_req = (op == OP_READ);
    rd_row = addr[ADDR_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q <= 1'b0;
      rd_a0_q  <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
    end else begin
      rd_vld_q <= (op == OP_READ);
      if (op == OP_READ) rd_a0_q <= addr[0];
      wr_en <= (op == OP_WRITE);
      if (op == OP_WRITE) wr_addr <= addr;
    end
  end
endmodule

// File: rtl/b2sram_array.sv
// Storage split into two banks (address bit 0) times LANES lanes, each a
// simple read-first RAM, plus a same-edge write-to-read bypass per lane.
module b2sram_array #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LANES  = 2,
  localparam int unsigned ROW_W = ADDR_W - 1,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned DW    = LANES * b2sram_pkg::LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic [ROW_W-1:0]     rd_row,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wd0,
  input  logic [DW-1:0]        wd1,
  input  logic [LANES-1:0]     wbe0_n,
  input  logic [LANES-1:0]     wbe1_n,
  output logic [1:0][DW-1:0]   q
);
  import b2sram_pkg::*;

  logic [ROW_W-1:0] wr_row;
  assign wr_row = wr_addr[ADDR_W-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    // beat 0 lands in the bank named by the address low bit
    logic takes_beat0;
    assign takes_beat0 = (wr_addr[0] == 1'(b));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [ROWS];
      logic [LANE_W-1:0] rd_q;
      logic [LANE_W-1:0] byp_q;
      logic [LANE_W-1:0] wdat;
      logic              wen;
      logic              byp_hit;

      always_comb begin
        wdat = takes_beat0 ? wd0[l*LANE_W +: LANE_W] : wd1[l*LANE_W +: LANE_W];
        wen  = wr_en & ~(takes_beat0 ? wbe0_n[l] : wbe1_n[l]);
      end

      always_ff @(posedge clk) begin
        if (wen) mem[wr_row] <= wdat;
        if (rd_req) rd_q <= mem[rd_row];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          byp_hit <= 1'b0;
          byp_q   <= '0;
        end else begin
          byp_hit <= rd_req & wen & (wr_row == rd_row);
          if (rd_req) byp_q <= wdat;
        end
      end

      assign q[b][l*LANE_W +: LANE_W] = byp_hit ? byp_q : rd_q;
    end
  end
endmodule

// File: rtl/b2sram_rdpipe.sv
// Orders the two words into beats, delays them, selects the output
// reference tap and runs the echo pair.
module b2sram_rdpipe #(
  parameter int unsigned DW       = 18,
  parameter int unsigned RD_EXTRA = 1,
  localparam int unsigned DEPTH   = RD_EXTRA + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_in,
  input  logic               a0_in,
  input  logic [1:0][DW-1:0] q,
  input  logic               oref_tied,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_rise,
  output logic [DW-1:0]      rd_fall,
  output logic               echo_p,
  output logic               echo_n
);
  logic [DEPTH-1:0]          pv;
  logic [DEPTH-1:0][DW-1:0]  pr;
  logic [DEPTH-1:0][DW-1:0]  pf;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      pr <= '0;
      pf <= '0;
    end else begin
      pv[0] <= vld_in;
      pr[0] <= vld_in ? q[a0_in]  : '0;
      pf[0] <= vld_in ? q[~a0_in] : '0;
      for (int i = 1; i < DEPTH; i++) begin
        pv[i] <= pv[i-1];
        pr[i] <= pr[i-1];
        pf[i] <= pf[i-1];
      end
    end
  end

  // output clocks in use add the last stage
  always_comb begin
    if (oref_tied) begin
      rd_valid = pv[DEPTH-2];
      rd_rise  = pr[DEPTH-2];
      rd_fall  = pf[DEPTH-2];
    end else begin
      rd_valid = pv[DEPTH-1];
      rd_rise  = pr[DEPTH-1];
      rd_fall  = pf[DEPTH-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      echo_p <= 1'b0;
      echo_n <= 1'b1;
    end else begin
      echo_p <= ~echo_p;
      echo_n <= ~echo_n;
    end
  end
endmodule

// File: rtl/b2sram_core.sv
module b2sram_core #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned LANES    = 2,
  parameter int unsigned RD_EXTRA = 1,
  localparam int unsigned DW      = LANES * b2sram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wd_rise,
  input  logic [DW-1:0]     wd_fall,
  input  logic [LANES-1:0]  wbe_rise_n,
  input  logic [LANES-1:0]  wbe_fall_n,
  input  logic              oref_tied,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_rise,
  output logic [DW-1:0]     rd_fall,
  output logic              echo_p,
  output logic              echo_n
);
  logic                rd_req;
  logic [ADDR_W-2:0]   rd_row;
  logic                rd_vld_q;
  logic                rd_a0_q;
  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr;
  logic [1:0][DW-1:0]  bank_q;

  b2sram_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .load_n(load_n), .rw(rw), .addr(addr),
    .rd_req(rd_req), .rd_row(rd_row), .rd_vld_q(rd_vld_q), .rd_a0_q(rd_a0_q),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  b2sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_row(rd_row),
    .wr_en(wr_en), .wr_addr(wr_addr), .wd0(wd_rise), .wd1(wd_fall),
    .wbe0_n(wbe_rise_n), .wbe1_n(wbe_fall_n), .q(bank_q)
  );

  b2sram_rdpipe #(.DW(DW), .RD_EXTRA(RD_EXTRA)) u_rdpipe (
    .clk(clk), .rst(rst), .vld_in(rd_vld_q), .a0_in(rd_a0_q), .q(bank_q),
    .oref_tied(oref_tied), .rd_valid(rd_valid), .rd_rise(rd_rise),
    .rd_fall(rd_fall), .echo_p(echo_p), .echo_n(echo_n)
  );
endmodule

// File: rtl/b2sram_checker.sv
module b2sram_checker #(
  parameter int unsigned DW       = 18,
  parameter int unsigned RD_EXTRA = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          load_n,
  input logic          rw,
  input logic          oref_tied,
  input logic          rd_valid,
  input logic [DW-1:0] rd_rise,
  input logic [DW-1:0] rd_fall,
  input logic          echo_p,
  input logic          echo_n
);
  logic                armed;
  logic [RD_EXTRA+2:0] rd_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      rd_hist <= '0;
    end else begin
      armed   <= 1'b1;
      rd_hist <= {rd_hist[RD_EXTRA+1:0], (!load_n && rw)};
    end
  end

  assert_echo_toggle_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    echo_p != $past(echo_p));

  assert_echo_pair_R9: assert property (@(posedge clk) disable iff (rst)
    echo_n == !echo_p);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_rise == '0 && rd_fall == '0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (oref_tied ? rd_hist[RD_EXTRA+1] : rd_hist[RD_EXTRA+2]));
endmodule

bind b2sram_core b2sram_checker #(.DW(DW), .RD_EXTRA(RD_EXTRA)) i_b2sram_checker (
  .clk(clk), .rst(rst), .load_n(load_n), .rw(rw), .oref_tied(oref_tied),
  .rd_valid(rd_valid), .rd_rise(rd_rise), .rd_fall(rd_fall),
  .echo_p(echo_p), .echo_n(echo_n)
);

// File: tb/test_b2sram_core.sv
module test_b2sram_core;
  localparam int AW  = 5;
  localparam int RDX = 1;
  localparam int DW  = 18;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd_rise = '0, wd_fall = '0;
  logic [1:0]    wbe_rise_n = 2'b11, wbe_fall_n = 2'b11;
  logic          oref_tied = 1'b1;
  logic          rd_valid, echo_p, echo_n;
  logic [DW-1:0] rd_rise, rd_fall;

  always #5 clk = ~clk;

  b2sram_core #(.ADDR_W(AW), .LANES(2), .RD_EXTRA(RDX)) i_b2sram_core (
    .clk(clk), .rst(rst), .load_n(load_n), .rw(rw), .addr(addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wbe_rise_n(wbe_rise_n),
    .wbe_fall_n(wbe_fall_n), .oref_tied(oref_tied), .rd_valid(rd_valid),
    .rd_rise(rd_rise), .rd_fall(rd_fall), .echo_p(echo_p), .echo_n(echo_n)
  );

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  logic [DW-1:0] model [NW];
  logic          exp_v [16];
  logic [DW-1:0] exp_r [16];
  logic [DW-1:0] exp_f [16];
  logic          pend_wr = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic          last_echo = 1'b0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [1:0] ben);
    logic [DW-1:0] r;
    r = old_w;
    if (!ben[0]) r[8:0]  = new_w[8:0];
    if (!ben[1]) r[17:9] = new_w[17:9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, t, act, exp);
    end
  endtask

  // one cycle: check outputs, update the model, drive the next inputs
  task automatic cyc(input logic ld_n, input logic dir, input logic [AW-1:0] a,
                     input logic [DW-1:0] dr, input logic [DW-1:0] df,
                     input logic [1:0] br, input logic [1:0] bf);
    int lat;
    int s;
    @(negedge clk);
    t++;
    s = t % 16;
    chk(rd_valid == exp_v[s], "R6 rd_valid", {17'd0, rd_valid}, {17'd0, exp_v[s]});
    if (exp_v[s]) begin
      chk(rd_rise == exp_r[s], "R2 rd_rise word", rd_rise, exp_r[s]);
      chk(rd_fall == exp_f[s], "R2 rd_fall word", rd_fall, exp_f[s]);
    end else begin
      chk(rd_rise == '0 && rd_fall == '0, "R7 idle beats zero", rd_rise | rd_fall, '0);
    end
    chk(echo_p != last_echo, "R9 echo toggle", {17'd0, echo_p}, {17'd0, ~last_echo});
    chk(echo_n == ~echo_p, "R9 echo pair", {17'd0, echo_n}, {17'd0, ~echo_p});
    last_echo = echo_p;
    exp_v[s] = 1'b0;
    // R3 R4: pending write takes this cycle's beats
    if (pend_wr) begin
      model[pend_addr]        = merge(model[pend_addr], dr, br);
      model[pend_addr ^ 5'd1] = merge(model[pend_addr ^ 5'd1], df, bf);
    end
    pend_wr   = (!ld_n && !dir);
    pend_addr = a;
    if (!ld_n && dir) begin
      lat = oref_tied ? RDX + 1 : RDX + 2;
      s = (t + 1 + lat) % 16;
      exp_v[s] = 1'b1;
      exp_r[s] = model[a];
      exp_f[s] = model[a ^ 5'd1];
    end
    load_n = ld_n; rw = dir; addr = a;
    wd_rise = dr; wd_fall = df; wbe_rise_n = br; wbe_fall_n = bf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc(1'b1, 1'($urandom), 5'($urandom), 18'($urandom), 18'($urandom), 2'b00, 2'b00);
  endtask

  task automatic rnd(input int n);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 3) == 0, 1'($urandom), 5'($urandom), 18'($urandom),
          18'($urandom), 2'($urandom), 2'($urandom));
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(rd_valid == 1'b0, "R10 reset valid", {17'd0, rd_valid}, '0);
    chk(rd_rise == '0 && rd_fall == '0, "R10 reset beats", rd_rise | rd_fall, '0);
    chk(echo_p == 1'b0 && echo_n == 1'b1, "R10 reset echo",
        {16'd0, echo_p, echo_n}, 18'd1);
    rst = 1'b0;
    // fill: write at even addresses, full enables (R3)
    for (int w = 0; w < NW / 2; w++) begin
      cyc(1'b0, 1'b0, 5'(2 * w), '0, '0, 2'b11, 2'b11);
      cyc(1'b1, 1'b0, '0, 18'(w * 1111 + 3), 18'(w * 777 + 5), 2'b00, 2'b00);
    end
    idle(2);
    for (int w = 0; w < NW; w++) cyc(1'b0, 1'b1, 5'(w), '0, '0, 2'b00, 2'b00); // R2
    idle(4);
    // R3 odd-address write, then R5: data cycle carries a stray address
    cyc(1'b0, 1'b0, 5'd7, '0, '0, 2'b11, 2'b11);
    cyc(1'b1, 1'b1, 5'd20, 18'h2AAAA, 18'h15555, 2'b00, 2'b00);
    cyc(1'b0, 1'b1, 5'd6, '0, '0, 2'b11, 2'b11);
    cyc(1'b0, 1'b1, 5'd20, '0, '0, 2'b11, 2'b11);
    idle(4);
    // R8 write then read same pair next cycle, lanes masked (R4)
    cyc(1'b0, 1'b0, 5'd12, '0, '0, 2'b11, 2'b11);
    cyc(1'b0, 1'b1, 5'd13, 18'h3FFFF, 18'h00000, 2'b10, 2'b01);
    cyc(1'b0, 1'b1, 5'd12, '0, '0, 2'b11, 2'b11);
    idle(4);
    // R1 deselected cycles must not write or read
    idle(10);
    for (int w = 0; w < NW; w++) cyc(1'b0, 1'b1, 5'(w), '0, '0, 2'b00, 2'b00);
    rnd(400);
    idle(8);
    oref_tied = 1'b0; // R6 output clocks in use
    rnd(400);
    for (int w = 0; w < NW; w++) cyc(1'b0, 1'b1, 5'(w), '0, '0, 2'b00, 2'b00);
    idle(8);
    oref_tied = 1'b1;
    rnd(200);
    idle(8);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule